// File: doc/BRIEF.md
# Preset Up/Down Event Counter

This block keeps a signed event count driven by two separate pulse inputs: one
that raises the count and one that lowers it. Only the rising transition of each
input is counted, so an input that stays high for many cycles adds or removes
exactly one event. A synchronous clear forces the count to zero. A load input
copies a signed preset into the count, which lets the count start from any value.

Two comparison flags follow the count at all times. One reports that the count
has reached or passed the preset. The other reports that the count has fallen to
zero or below. The count saturates at the limits of its signed width instead of
wrapping, so a long burst of events can never flip either flag falsely.

Top module: `updn_counter`

## Requirements
- R1: A rising edge on `count_up` alone raises `count` by one at the clock edge where the input is first sampled high; a rising edge on `count_dn` alone lowers it by one in the same way.
- R2: An input held high after its rising edge adds no further events; `count` stays unchanged while the input level stays high.
- R3: `clr` (active high, synchronous) sets `count` to 0 at the next clock edge, overriding `load` and both count inputs. It also clears the edge history, so a count input that is high when `clr` drops counts once in the first cycle after the release.
- R4: `load` (active high) copies `preset` into `count` at the next clock edge and overrides both count inputs; a count edge that arrives during a load is not counted later.
- R5: When rising edges on `count_up` and `count_dn` are detected in the same cycle, `count` is left unchanged.
- R6: `count` is a 16-bit two's complement value that stays at 32767 on a further up event and at -32768 on a further down event.
- R7: `at_or_above` is 1 exactly when `count` is greater than or equal to `preset`, both read as signed, and follows `preset` without a clock delay.
- R8: `at_or_below_zero` is 1 exactly when `count`, read as signed, is less than or equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of count and edge history |
| load | input | 1 | Copy preset into count |
| count_up | input | 1 | Up event input, rising edge counted |
| count_dn | input | 1 | Down event input, rising edge counted |
| preset | input | 16 | Signed preset value |
| count | output | 16 | Signed current count |
| at_or_above | output | 1 | Count is at or above preset |
| at_or_below_zero | output | 1 | Count is at or below zero |

## Verification
Each stimulus cycle is applied on the falling clock edge, and its effect on `count` is due at the very next rising edge, since one register sits between the inputs and the count; the two flags are combinational from that register and from `preset`, so they are due in the same cycle. The driver pushes one expected triple per applied cycle and the monitor samples shortly after each rising edge, before the next falling edge changes any input, so every sample belongs to exactly one stimulus. Held levels, simultaneous edges, load during an edge, release of clear with an input high and both saturation limits each get dedicated sequences.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Action chosen for the count register in one cycle, by priority.
  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_CLR  = 3'd1,
    ACT_LOAD = 3'd2,
    ACT_UP   = 3'd3,
    ACT_DN   = 3'd4
  } updn_act_e;

  localparam int unsigned CH_UP = 0;
  localparam int unsigned CH_DN = 1;
  localparam int unsigned N_CH  = 2;

endpackage

// File: rtl/updn_edge.sv
module updn_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (clr) prev_q[g] <= 1'b0;
      else     prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end

  // R2: a level that was already high one cycle ago never reports an edge
  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r2_no_repeat_edge: assert property (@(posedge clk) disable iff (clr)
      (lvl[g] && $past(lvl[g]) && !$past(clr)) |-> !rise[g]);
  end

endmodule

// File: rtl/updn_arbiter.sv
module updn_arbiter
  import updn_pkg::*;
(
  input  logic      clr,
  input  logic      load,
  input  logic      up_rise,
  input  logic      dn_rise,
  output updn_act_e act
);

  always_comb begin
    if (clr)                    act = ACT_CLR;
    else if (load)              act = ACT_LOAD;
    else if (up_rise && !dn_rise) act = ACT_UP;
    else if (dn_rise && !up_rise) act = ACT_DN;
    else                        act = ACT_HOLD;
  end

endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                clr,
  input  updn_act_e           act,
  input  logic signed [W-1:0] pv,
  output logic signed [W-1:0] cv
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // One saturating step in the requested direction.
  function automatic logic signed [W-1:0] sat_step(
    input logic signed [W-1:0] v,
    input logic                go_up
  );
    if (go_up) return (v == MAXV) ? v : v + 1'b1;
    else       return (v == MINV) ? v : v - 1'b1;
  endfunction

  logic signed [W-1:0] cv_q;
  logic signed [W-1:0] cv_d;

  always_comb begin
    unique case (act)
      ACT_CLR:  cv_d = '0;
      ACT_LOAD: cv_d = pv;
      ACT_UP:   cv_d = sat_step(cv_q, 1'b1);
      ACT_DN:   cv_d = sat_step(cv_q, 1'b0);
      default:  cv_d = cv_q;
    endcase
  end

  always_ff @(posedge clk) begin
    cv_q <= cv_d;
  end

  assign cv = cv_q;

  // R1: an up action below the top limit adds exactly one
  a_r1_up_step: assert property (@(posedge clk) disable iff (clr)
    (act == ACT_UP && cv_q != MAXV) |=> (cv_q == $past(cv_q) + 1'b1));

  // R1: a down action above the bottom limit removes exactly one
  a_r1_dn_step: assert property (@(posedge clk) disable iff (clr)
    (act == ACT_DN && cv_q != MINV) |=> (cv_q == $past(cv_q) - 1'b1));

  // R6: no wrap at the top limit
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (clr)
    (act == ACT_UP && cv_q == MAXV) |=> (cv_q == MAXV));

  // R6: no wrap at the bottom limit
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (clr)
    (act == ACT_DN && cv_q == MINV) |=> (cv_q == MINV));

endmodule

// File: rtl/updn_flags.sv
module updn_flags #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] cv,
  input  logic signed [W-1:0] pv,
  output logic                qu,
  output logic                qd
);

  localparam logic signed [W-1:0] ZERO = '0;

  always_comb begin
    qu = (cv >= pv);
    qd = (cv <= ZERO);
  end

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic         count_up,
  input  logic         count_dn,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         at_or_above,
  output logic         at_or_below_zero
);

  logic [N_CH-1:0]     lvl;
  logic [N_CH-1:0]     rise;
  logic                up_rise;
  logic                dn_rise;
  updn_act_e           act;
  logic signed [W-1:0] pv_s;
  logic signed [W-1:0] cv_s;

  assign lvl[CH_UP] = count_up;
  assign lvl[CH_DN] = count_dn;
  assign up_rise    = rise[CH_UP];
  assign dn_rise    = rise[CH_DN];
  assign pv_s       = $signed(preset);

  updn_edge #(.N(N_CH)) u_edge (
    .clk  (clk),
    .clr  (clr),
    .lvl  (lvl),
    .rise (rise)
  );

  updn_arbiter u_arb (
    .clr     (clr),
    .load    (load),
    .up_rise (up_rise),
    .dn_rise (dn_rise),
    .act     (act)
  );

  updn_core #(.W(W)) u_core (
    .clk (clk),
    .clr (clr),
    .act (act),
    .pv  (pv_s),
    .cv  (cv_s)
  );

  updn_flags #(.W(W)) u_flags (
    .cv (cv_s),
    .pv (pv_s),
    .qu (at_or_above),
    .qd (at_or_below_zero)
  );

  assign count = cv_s;

  // R4: load places the preset into the count one edge later
  a_r4_load: assert property (@(posedge clk) disable iff (clr)
    load |=> (count == $past(preset)));

  // R5: coincident edges leave the count alone
  a_r5_cancel: assert property (@(posedge clk) disable iff (clr)
    (up_rise && dn_rise && !load) |=> $stable(count));

  // R2: with no edge and no load the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (clr)
    (!up_rise && !dn_rise && !load) |=> $stable(count));

  // R3: clear drives the count to zero at the following edge
  a_r3_clear: assert property (@(posedge clk) disable iff (load && !clr)
    clr |=> (count == '0));

endmodule

// File: tb/updn_counter_test.sv
`timescale 1ns/1ps
module updn_counter_test;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        load = 1'b0;
  logic        count_up = 1'b0;
  logic        count_dn = 1'b0;
  logic [15:0] preset = '0;
  logic [15:0] count;
  logic        at_or_above;
  logic        at_or_below_zero;

  always #2.5 clk = ~clk;

  updn_counter uut (
    .clk              (clk),
    .clr              (clr),
    .load             (load),
    .count_up         (count_up),
    .count_dn         (count_dn),
    .preset           (preset),
    .count            (count),
    .at_or_above      (at_or_above),
    .at_or_below_zero (at_or_below_zero)
  );

  typedef struct {
    int    cv;
    bit    qu;
    bit    qd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  // reference state
  int m_cv = 0;
  bit m_pu = 0;
  bit m_pd = 0;

  task automatic step(input bit c, input bit l, input bit u, input bit d,
                      input int pv, input string tag);
    exp_t e;
    bit eu, ed;
    @(negedge clk);
    clr = c; load = l; count_up = u; count_dn = d; preset = 16'(pv);
    eu = u && !m_pu;
    ed = d && !m_pd;
    if (c) m_cv = 0;
    else if (l) m_cv = pv;
    else if (eu != ed) begin
      if (eu && m_cv < 32767) m_cv = m_cv + 1;
      if (ed && m_cv > -32768) m_cv = m_cv - 1;
    end
    m_pu = c ? 1'b0 : u;
    m_pd = c ? 1'b0 : d;
    e.cv = m_cv; e.qu = (m_cv >= pv); e.qd = (m_cv <= 0); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pop one expected item per edge, sampled after the update
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      exp_t e;
      int got;
      e = exp_q.pop_front();
      got = int'($signed(count));
      total++;
      if (got != e.cv || at_or_above != e.qu || at_or_below_zero != e.qd) begin
        bad++;
        $display("FAIL %s: count=%0d qu=%0b qd=%0b expected count=%0d qu=%0b qd=%0b",
                 e.tag, got, at_or_above, at_or_below_zero, e.cv, e.qu, e.qd);
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R3 reset state
    step(1, 0, 0, 0, 200, "R3 reset");
    step(1, 0, 0, 0, 200, "R3 reset hold");
    // R1 up pulses, R7/R8 flags with preset 200
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 0, 200, "R1 up edge");
      step(0, 0, 0, 0, 200, "R1 up low");
    end
    // R2 held high counts once
    step(0, 0, 1, 0, 200, "R2 held edge");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 200, "R2 held level");
    step(0, 0, 0, 0, 200, "R2 release");
    // R1 down pulses across zero, R8
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 1, 200, "R1 R8 down edge");
      step(0, 0, 0, 0, 200, "R8 down low");
    end
    // R5 simultaneous edges
    step(0, 0, 1, 1, 200, "R5 both edges");
    step(0, 0, 0, 0, 200, "R5 both low");
    // R4 load 178, then climb to preset 200 via loads and ups (R7)
    step(0, 1, 0, 0, 200, "R4 R7 load 178 wrong pv");
    step(0, 1, 0, 0, 178, "R4 load 178");
    step(0, 0, 0, 0, 200, "R7 below preset");
    step(0, 1, 0, 0, 199, "R4 load 199");
    step(0, 0, 1, 0, 200, "R7 reach preset");
    step(0, 0, 0, 0, 200, "R7 at preset");
    step(0, 0, 0, 0, 201, "R7 preset moves up");
    step(0, 0, 0, 0, -5, "R7 negative preset");
    // R4 load overrides an edge, edge not counted later
    step(0, 1, 1, 0, 50, "R4 load with edge");
    step(0, 0, 1, 0, 50, "R4 edge consumed");
    step(0, 0, 0, 0, 50, "R4 after");
    // R3 clear overrides load and edges
    step(1, 1, 0, 1, 50, "R3 clear beats load");
    step(1, 0, 1, 0, 50, "R3 clear with up high");
    step(0, 0, 1, 0, 50, "R3 edge after release");
    step(0, 0, 0, 0, 50, "R3 low");
    // R6 top saturation
    step(0, 1, 0, 0, 32767, "R6 load max");
    step(0, 0, 1, 0, 32767, "R6 up at max");
    step(0, 0, 0, 0, 32767, "R6 low");
    step(0, 0, 1, 0, 32767, "R6 up at max again");
    step(0, 0, 0, 1, 32767, "R1 down from max");
    step(0, 0, 0, 0, 32767, "R1 low");
    // R6 bottom saturation
    step(0, 1, 0, 0, -32768, "R6 load min");
    step(0, 0, 0, 1, -32768, "R6 down at min");
    step(0, 0, 0, 0, -32768, "R6 low");
    step(0, 0, 0, 1, -32768, "R6 down at min again");
    step(0, 0, 1, 0, -32768, "R1 up from min");
    step(0, 0, 0, 0, -32768, "R8 low");
    // drain the scoreboard
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule